// File: doc/BRIEF.md
# Multi-Counter Performance Monitor Unit

This block is a core-local bank of ten 48-bit event counters. Counter 0 counts core-active cycles and counter 1 counts retired instructions; both are fixed. Counters 2 to 9 each take an 8-bit event code from one of two packed select registers. The code picks one line of a 256-wide event bus from the core. A counter advances by one in a cycle when three things hold: its selected event is high, it is enabled, and the current privilege level (user or kernel) is one it is qualified for.

When bit 47 of a counter goes from 0 to 1 through counting, an overflow is recorded in a status register. If that counter's interrupt enable is set, an interrupt-active flag is raised. The interrupt line is driven while three things hold: fast-interrupt mode is selected, the active flag is set, and an interrupt-enabled overflow is still pending. Software configures the block, reads the counters and writes them through a simple register bus with a 5-bit address and 64-bit data. The read path is combinational.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counters, enables, privilege qualifiers, event selects, status bits, the interrupt mode and the active flag are zero, and `irq_o` is low.
- R2: Counter 0 counts cycles with `cyc_active_i` high and counter 1 counts cycles with `retire_i` high. Neither one depends on the event-select registers.
- R3: The select register at address 2 holds the code for counter n (2..5) in bits [(n-2)*8 +: 8]. The select register at address 3 holds the code for counter n (6..9) in bits [(n-6)*8 +: 8]. A programmable counter counts cycles in which `evt_bus_i[code]` is high.
- R4: Control register (address 0) layout: count enables of counters 0..7 in bits [7:0], of counters 8..9 in bits [17:16]. A counter whose enable is clear does not move. An enabled, qualified counter rises by exactly one for each clock edge at which its event is high, and the new value is visible after that edge.
- R5: Privilege register (address 1) layout: user qualifiers of counters 0..7 in [7:0] and 8..9 in [17:16]; kernel qualifiers of counters 0..7 in [15:8] and 8..9 in [19:18]. With `priv_krn_i`=1 a counter needs its kernel bit, and with 0 it needs its user bit.
- R6: Counters are 48 bits and wrap. An increment that takes bit 47 from 0 to 1 sets that counter's bit in the status register (address 4, bit n for counter n). A software write that sets bit 47, or a wrap from all ones to zero, sets no status bit.
- R7: Status bits are write-one-to-clear. Writing 0 leaves a bit unchanged.
- R8: The active flag (control bit 21) is set when a counter overflows with its interrupt enable set. Interrupt enables sit in control bits [15:8] for counters 0..7 and [19:18] for counters 8..9. Writing 0 to bit 21 clears the flag; writing 1 leaves it as it is.
- R9: `irq_o` is high exactly when the mode bit (control bit 20, 1 = fast interrupt) is 1, the active flag is set, and some status bit is set whose interrupt enable is also set.
- R10: Address 8+n writes and reads counter n. A write takes priority over a same-cycle increment.
- R11: Reads are combinational; unmapped addresses read as zero, and the select registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_active_i | input | 1 | Core-active cycle event for counter 0 |
| retire_i | input | 1 | Retired-instruction event for counter 1 |
| evt_bus_i | input | 256 | Event lines selectable by counters 2..9 |
| priv_krn_i | input | 1 | Current privilege: 1 kernel, 0 user |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Register read data (combinational) |
| ctr_o | output | 480 | All counter values, counter n in bits [n*48 +: 48] |
| irq_o | output | 1 | Overflow interrupt |

## Verification
Events are driven just after a clock edge. Each high event cycle is counted at the following edge, so a counter's value is read only after the last counted edge. A register write lands at the edge where the strobe is sampled. Status, the active flag and `irq_o` reflect an overflow right after the edge that counted past bit 47, since `irq_o` is combinational from those registers. The driver sets the read address after an edge and queues the expected value. The monitor compares at the falling edge of that same cycle, which leaves half a period clear of any edge on both sides.

// File: rtl/perf_pkg.sv
package perf_pkg;

   // register map (word addresses)
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_PRIV  = 1;
   localparam int unsigned REG_SELA  = 2;
   localparam int unsigned REG_SELB  = 3;
   localparam int unsigned REG_STAT  = 4;
   localparam int unsigned CTR_BASE  = 8;

   // split of per-counter bits into a low group of eight and a high group
   localparam int unsigned GRP_LO    = 8;

   // control register fields
   localparam int unsigned CTRL_EN_LO = 0;
   localparam int unsigned CTRL_IE_LO = 8;
   localparam int unsigned CTRL_EN_HI = 16;
   localparam int unsigned CTRL_IE_HI = 18;
   localparam int unsigned CTRL_MODE  = 20;
   localparam int unsigned CTRL_ACT   = 21;

   // privilege register fields
   localparam int unsigned PRIV_U_LO = 0;
   localparam int unsigned PRIV_K_LO = 8;
   localparam int unsigned PRIV_U_HI = 16;
   localparam int unsigned PRIV_K_HI = 18;

   // counters with a hard-wired event, and slots per select register
   localparam int unsigned FIXED_CTRS = 2;
   localparam int unsigned SEL_SLOTS  = 4;

   typedef enum logic {IRQ_OFF = 1'b0, IRQ_FAST = 1'b1} irq_mode_e;

   function automatic int unsigned grp_pos(int unsigned idx, int unsigned lo, int unsigned hi);
      return (idx < GRP_LO) ? lo + idx : hi + idx - GRP_LO;
   endfunction

endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
   import perf_pkg::*;
#(
   parameter int unsigned EVT_W    = 8,
   parameter bit          IS_FIXED = 1'b0,
   localparam int unsigned N_EVT   = 1 << EVT_W
) (
   input  logic             fixed_i,
   input  logic [N_EVT-1:0] evt_bus_i,
   input  logic [EVT_W-1:0] code_i,
   input  logic             en_i,
   input  logic             usr_q_i,
   input  logic             krn_q_i,
   input  logic             priv_krn_i,
   output logic             inc_o
);

   logic hit;
   logic priv_ok;

   generate
      if (IS_FIXED) begin : g_fixed
         logic unused_sel;
         assign unused_sel = ^{code_i, evt_bus_i};
         assign hit        = fixed_i;
      end else begin : g_prog
         logic unused_fix;
         assign unused_fix = fixed_i;
         assign hit        = evt_bus_i[code_i];
      end
   endgenerate

   assign priv_ok = priv_krn_i ? krn_q_i : usr_q_i;
   assign inc_o   = hit & en_i & priv_ok;

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
   parameter int unsigned CTR_W = 48
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             inc_i,
   input  logic             wr_i,
   input  logic [CTR_W-1:0] wdata_i,
   output logic [CTR_W-1:0] cnt_o,
   output logic             ovf_o
);

   localparam int unsigned MSB = CTR_W - 1;

   if (CTR_W < 2) begin : g_bad_w
      $error("pmu_counter: CTR_W must be at least 2");
   end

   logic [CTR_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_q <= '0;
      else if (wr_i)  cnt_q <= wdata_i;
      else if (inc_i) cnt_q <= cnt_q + CTR_W'(1);
   end

   // top bit about to rise through counting
   assign ovf_o = inc_i & ~wr_i & ~cnt_q[MSB] & (&cnt_q[MSB-1:0]);
   assign cnt_o = cnt_q;

   assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !wr_i) |=> cnt_q == $past(cnt_q) + CTR_W'(1));
   assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_i) |=> $stable(cnt_q));
   assert_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> cnt_q == $past(wdata_i));
   assert_msb_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> (cnt_q[MSB] && cnt_q[MSB-1:0] == '0));

endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
   import perf_pkg::*;
#(
   parameter int unsigned NCTR   = 10,
   parameter int unsigned EVT_W  = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 64
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  we_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [NCTR-1:0]       ovf_i,
   output logic [NCTR-1:0]       cnt_en_o,
   output logic [NCTR-1:0]       usr_q_o,
   output logic [NCTR-1:0]       krn_q_o,
   output logic [NCTR*EVT_W-1:0] codes_o,
   output logic [DATA_W-1:0]     rdata_o,
   output logic                  irq_o
);

   localparam int unsigned SEL_W = SEL_SLOTS * EVT_W;

   if (NCTR != FIXED_CTRS + 2 * SEL_SLOTS) begin : g_bad_n
      $error("pmu_regs: register layout is defined for exactly ten counters");
   end
   if (SEL_W > DATA_W || CTRL_ACT >= DATA_W || NCTR > DATA_W) begin : g_bad_d
      $error("pmu_regs: DATA_W too narrow for the register layout");
   end

   logic [NCTR-1:0]  cnt_en_q, irq_en_q, usr_q, krn_q, stat_q;
   irq_mode_e        mode_q;
   logic             act_q;
   logic [SEL_W-1:0] sel_a_q, sel_b_q;

   logic wr_ctrl, wr_priv, wr_sela, wr_selb, wr_stat;
   logic act_set;
   logic unused_wd;

   assign wr_ctrl = we_i && (addr_i == ADDR_W'(REG_CTRL));
   assign wr_priv = we_i && (addr_i == ADDR_W'(REG_PRIV));
   assign wr_sela = we_i && (addr_i == ADDR_W'(REG_SELA));
   assign wr_selb = we_i && (addr_i == ADDR_W'(REG_SELB));
   assign wr_stat = we_i && (addr_i == ADDR_W'(REG_STAT));
   assign act_set = |(ovf_i & irq_en_q);
   assign unused_wd = ^wdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_en_q <= '0;
         irq_en_q <= '0;
         mode_q   <= IRQ_OFF;
      end else if (wr_ctrl) begin
         for (int i = 0; i < NCTR; i++) begin
            cnt_en_q[i] <= wdata_i[grp_pos(i, CTRL_EN_LO, CTRL_EN_HI)];
            irq_en_q[i] <= wdata_i[grp_pos(i, CTRL_IE_LO, CTRL_IE_HI)];
         end
         mode_q <= irq_mode_e'(wdata_i[CTRL_MODE]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         usr_q <= '0;
         krn_q <= '0;
      end else if (wr_priv) begin
         for (int i = 0; i < NCTR; i++) begin
            usr_q[i] <= wdata_i[grp_pos(i, PRIV_U_LO, PRIV_U_HI)];
            krn_q[i] <= wdata_i[grp_pos(i, PRIV_K_LO, PRIV_K_HI)];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_a_q <= '0;
         sel_b_q <= '0;
      end else begin
         if (wr_sela) sel_a_q <= wdata_i[SEL_W-1:0];
         if (wr_selb) sel_b_q <= wdata_i[SEL_W-1:0];
      end
   end

   // an overflow in the same cycle as a clear wins
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= '0;
      end else begin
         for (int i = 0; i < NCTR; i++) begin
            if (ovf_i[i])                     stat_q[i] <= 1'b1;
            else if (wr_stat && wdata_i[i])   stat_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           act_q <= 1'b0;
      else if (act_set)                      act_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[CTRL_ACT]) act_q <= 1'b0;
   end

   genvar g;
   generate
      for (g = 0; g < NCTR; g++) begin : g_code
         if (g < FIXED_CTRS) begin : g_none
            assign codes_o[g*EVT_W +: EVT_W] = '0;
         end else if (g < FIXED_CTRS + SEL_SLOTS) begin : g_a
            assign codes_o[g*EVT_W +: EVT_W] = sel_a_q[(g-FIXED_CTRS)*EVT_W +: EVT_W];
         end else begin : g_b
            assign codes_o[g*EVT_W +: EVT_W] = sel_b_q[(g-FIXED_CTRS-SEL_SLOTS)*EVT_W +: EVT_W];
         end
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(REG_CTRL)) begin
         for (int i = 0; i < NCTR; i++) begin
            rdata_o[grp_pos(i, CTRL_EN_LO, CTRL_EN_HI)] = cnt_en_q[i];
            rdata_o[grp_pos(i, CTRL_IE_LO, CTRL_IE_HI)] = irq_en_q[i];
         end
         rdata_o[CTRL_MODE] = mode_q;
         rdata_o[CTRL_ACT]  = act_q;
      end else if (addr_i == ADDR_W'(REG_PRIV)) begin
         for (int i = 0; i < NCTR; i++) begin
            rdata_o[grp_pos(i, PRIV_U_LO, PRIV_U_HI)] = usr_q[i];
            rdata_o[grp_pos(i, PRIV_K_LO, PRIV_K_HI)] = krn_q[i];
         end
      end else if (addr_i == ADDR_W'(REG_SELA)) begin
         rdata_o[SEL_W-1:0] = sel_a_q;
      end else if (addr_i == ADDR_W'(REG_SELB)) begin
         rdata_o[SEL_W-1:0] = sel_b_q;
      end else if (addr_i == ADDR_W'(REG_STAT)) begin
         rdata_o[NCTR-1:0] = stat_q;
      end
   end

   assign irq_o    = (mode_q == IRQ_FAST) && act_q && |(stat_q & irq_en_q);
   assign cnt_en_o = cnt_en_q;
   assign usr_q_o  = usr_q;
   assign krn_q_o  = krn_q;

   assert_stat_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_i != '0) |=> ((stat_q & $past(ovf_i)) == $past(ovf_i)));
   assert_act_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_set |=> act_q);
   assert_act_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(act_q) |-> $past(wr_ctrl && !wdata_i[CTRL_ACT]));
   assert_stat_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q != '0 && !wr_stat) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (mode_q == IRQ_FAST && act_q));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
   import perf_pkg::*;
#(
   parameter int unsigned NCTR   = 10,
   parameter int unsigned CTR_W  = 48,
   parameter int unsigned EVT_W  = 8,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned N_EVT = 1 << EVT_W
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  cyc_active_i,
   input  logic                  retire_i,
   input  logic [N_EVT-1:0]      evt_bus_i,
   input  logic                  priv_krn_i,
   input  logic                  we_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   output logic [NCTR*CTR_W-1:0] ctr_o,
   output logic                  irq_o
);

   if (CTR_W > DATA_W) begin : g_bad_cw
      $error("perf_counter_bank: counters wider than the data bus");
   end
   if (CTR_BASE + NCTR > (1 << ADDR_W)) begin : g_bad_aw
      $error("perf_counter_bank: ADDR_W cannot reach every counter");
   end

   logic [NCTR-1:0]       cnt_en, usr_q, krn_q, inc, ovf, ctr_wr;
   logic [NCTR*EVT_W-1:0] codes;
   logic [DATA_W-1:0]     reg_rd;
   logic [CTR_W-1:0]      cnt [NCTR];

   pmu_regs #(
      .NCTR(NCTR), .EVT_W(EVT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .ovf_i(ovf), .cnt_en_o(cnt_en), .usr_q_o(usr_q),
      .krn_q_o(krn_q), .codes_o(codes), .rdata_o(reg_rd), .irq_o(irq_o)
   );

   genvar g;
   generate
      for (g = 0; g < NCTR; g++) begin : g_ctr
         logic fixed_evt;
         if (g == 0) begin : g_cyc
            assign fixed_evt = cyc_active_i;
         end else if (g == 1) begin : g_ret
            assign fixed_evt = retire_i;
         end else begin : g_none
            assign fixed_evt = 1'b0;
         end

         assign ctr_wr[g] = we_i && (addr_i == ADDR_W'(CTR_BASE + g));

         pmu_event_sel #(
            .EVT_W(EVT_W), .IS_FIXED(g < FIXED_CTRS)
         ) u_sel (
            .fixed_i(fixed_evt), .evt_bus_i(evt_bus_i),
            .code_i(codes[g*EVT_W +: EVT_W]), .en_i(cnt_en[g]),
            .usr_q_i(usr_q[g]), .krn_q_i(krn_q[g]), .priv_krn_i(priv_krn_i),
            .inc_o(inc[g])
         );

         pmu_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc[g]), .wr_i(ctr_wr[g]),
            .wdata_i(wdata_i[CTR_W-1:0]), .cnt_o(cnt[g]), .ovf_o(ovf[g])
         );

         assign ctr_o[g*CTR_W +: CTR_W] = cnt[g];
      end
   endgenerate

   always_comb begin
      rdata_o = reg_rd;
      for (int i = 0; i < NCTR; i++) begin
         if (addr_i == ADDR_W'(CTR_BASE + i)) rdata_o = DATA_W'(cnt[i]);
      end
   end

   assert_fixed_cyc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cyc_active_i && !ctr_wr[0]) |=> $stable(cnt[0]));
   assert_fixed_ret_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!retire_i && !ctr_wr[1]) |=> $stable(cnt[1]));
   assert_one_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(ovf & ~inc) == 0);

endmodule

// File: tb/sim_perf_counter_bank.sv
`timescale 1ns/1ps
module sim_perf_counter_bank;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [257:0] stim = '0;
   logic         priv = 1'b1;
   logic         we = 1'b0;
   logic [4:0]   addr = '0;
   logic [63:0]  wdata = '0;
   logic [63:0]  rdata;
   logic [479:0] ctr;
   logic         irq;

   int n_chk = 0;
   int n_fail = 0;
   bit mon_vld = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [63:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   always #2 clk = ~clk;

   perf_counter_bank u0 (
      .clk_i(clk), .rst_ni(rst_n), .cyc_active_i(stim[256]), .retire_i(stim[257]),
      .evt_bus_i(stim[255:0]), .priv_krn_i(priv), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .ctr_o(ctr), .irq_o(irq)
   );

   // monitor: compares the queued expectation at the falling edge
   always @(negedge clk) begin : mon
      item_t       it;
      logic [63:0] got;
      if (mon_vld) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL scoreboard empty act=%h exp=none", rdata);
         end else begin
            it  = sb.pop_front();
            got = it.is_irq ? {63'd0, irq} : rdata;
            if (got !== it.exp) begin
               n_fail++;
               $display("FAIL %s act=%h exp=%h", it.tag, got, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [4:0] a, input logic [63:0] d);
      @(posedge clk); #1;
      we = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [63:0] e, input string t);
      @(posedge clk); #1;
      addr = a;
      sb.push_back('{1'b0, e, t});
      mon_vld = 1'b1;
      @(posedge clk); #1;
      mon_vld = 1'b0;
   endtask

   task automatic irq_chk(input logic e, input string t);
      @(posedge clk); #1;
      sb.push_back('{1'b1, {63'd0, e}, t});
      mon_vld = 1'b1;
      @(posedge clk); #1;
      mon_vld = 1'b0;
   endtask

   // hold one stimulus line high across n clock edges
   task automatic ev(input int idx, input int n);
      @(posedge clk); #1;
      stim[idx] = 1'b1;
      repeat (n) @(posedge clk);
      #1 stim[idx] = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(5'd0, 64'h0, "R1 ctrl reset");
      rd_chk(5'd8, 64'h0, "R1 counter0 reset");
      rd_chk(5'd4, 64'h0, "R1 status reset");
      rd_chk(5'd2, 64'h0, "R1 select reset");
      irq_chk(1'b0, "R1 irq reset");

      // selects written first: fixed counters must not care (R2)
      wr(5'd2, 64'h2000_0010);
      wr(5'd3, 64'hFF00_3005);
      rd_chk(5'd3, 64'hFF00_3005, "R11 select readback");
      wr(5'd1, 64'h300);
      wr(5'd0, 64'h3);
      ev(256, 5);
      ev(257, 3);
      rd_chk(5'd8, 64'd5, "R2 cycle counter");
      rd_chk(5'd9, 64'd3, "R2 retire counter");

      // programmable counters (R3, R4)
      wr(5'd1, 64'h86700);
      wr(5'd0, 64'h20067);
      ev(8'h10, 4);
      ev(8'h20, 2);
      ev(8'hFF, 3);
      ev(8'h05, 1);
      ev(0, 2);
      rd_chk(5'd10, 64'd4, "R3 counter2 code 0x10");
      rd_chk(5'd13, 64'd2, "R3 counter5 code 0x20");
      rd_chk(5'd17, 64'd3, "R3 counter9 code 0xFF");
      rd_chk(5'd14, 64'd1, "R3 counter6 code 0x05");
      rd_chk(5'd11, 64'd0, "R4 disabled counter3 idle");

      // privilege qualifiers (R5)
      priv = 1'b0;
      ev(8'h10, 2);
      rd_chk(5'd10, 64'd4, "R5 user level not qualified");
      wr(5'd1, 64'h86704);
      ev(8'h10, 2);
      rd_chk(5'd10, 64'd6, "R5 user level qualified");

      // software write of bit 47 is not an overflow (R6)
      wr(5'd12, 64'h8000_0000_0000);
      rd_chk(5'd4, 64'h0, "R6 write sets no status");

      // overflow path (R6, R8, R9)
      wr(5'd1, 64'h86784);
      wr(5'd15, 64'h7FFF_FFFF_FFFE);
      wr(5'd0, 64'h1280E7);
      ev(8'h30, 1);
      rd_chk(5'd15, 64'h7FFF_FFFF_FFFF, "R4 counter7 one step");
      irq_chk(1'b0, "R9 no irq before overflow");
      ev(8'h30, 1);
      rd_chk(5'd4, 64'h80, "R6 status bit7 on overflow");
      rd_chk(5'd0, 64'h3280E7, "R8 active flag set");
      irq_chk(1'b1, "R9 irq raised");

      // mode off masks the line, writing 1 to active keeps it (R9, R8)
      wr(5'd0, 64'h2280E7);
      irq_chk(1'b0, "R9 mode off");
      rd_chk(5'd0, 64'h2280E7, "R8 active kept");
      wr(5'd0, 64'h3280E7);
      irq_chk(1'b1, "R9 mode fast again");

      // write-one-to-clear status (R7)
      wr(5'd4, 64'h0);
      rd_chk(5'd4, 64'h80, "R7 write zero keeps");
      wr(5'd4, 64'h80);
      rd_chk(5'd4, 64'h0, "R7 write one clears");
      irq_chk(1'b0, "R9 nothing pending");
      wr(5'd0, 64'h1280E7);
      rd_chk(5'd0, 64'h1280E7, "R8 active cleared by zero");

      // write beats a same-cycle increment (R10)
      priv = 1'b1;
      @(posedge clk); #1 stim[8'h10] = 1'b1;
      wr(5'd10, 64'd100);
      stim[8'h10] = 1'b0;
      rd_chk(5'd10, 64'd100, "R10 write wins over increment");
      if (ctr[2*48 +: 48] !== 48'd100) begin
         n_fail++;
         $display("FAIL R10 ctr_o slice act=%h exp=%h", ctr[2*48 +: 48], 48'd100);
      end
      n_chk++;

      // full wrap sets no status (R6)
      priv = 1'b0;
      wr(5'd15, 64'hFFFF_FFFF_FFFF);
      ev(8'h30, 1);
      rd_chk(5'd15, 64'h0, "R6 counter wraps to zero");
      rd_chk(5'd4, 64'h0, "R6 wrap sets no status");

      // unmapped read (R11)
      rd_chk(5'd5, 64'h0, "R11 unmapped reads zero");

      @(posedge clk); #1;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard leftover act=%0d exp=0", sb.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule